// File: doc/BRIEF.md
# Tagged Cached Two-Level Branch Direction Predictor

This block forecasts whether a conditional branch will be taken. It keeps a short outcome history for each branch, held in a small direct-mapped table indexed by low program-counter bits. A lookup forms a key from the full branch address and that history. It then searches a small fully associative prediction cache in which every entry carries a valid bit and a complete tag, so an entry answers only for the exact address and history context that created it.

When the key is absent from the cache, a second stage answers instead. This second stage is a direct-mapped table of two-bit saturating counters indexed by PC bits.

The lookup port is purely combinational and reports a direction and a flag saying whether the cache supplied it. The update port takes a resolved branch and does four things at the next clock edge: it trains the matching cache entry or allocates a new one, it trains the second-stage counter, advances the branch history and refreshes the replacement order.

Top module: `cached_branch_predictor`

## Requirements
- R1: Lookup outputs depend combinationally on `lk_pc` and the current state. An update changes the state only at the next rising edge, so a lookup in the same cycle as an update to the same context sees the value from before the update.
- R2: Only a valid cache entry can produce `lk_hit`=1. Right after reset no lookup hits.
- R3: A hit requires equality of the whole PC and the whole history value. Branches that share a history index or a second-stage index never share a cache entry.
- R4: On a miss, `lk_taken` is bit 1 of the second-stage counter selected by the low `BASE_IDX_W` PC bits.
- R5: The second-stage counter is a 2-bit saturating counter. Values 2 and 3 predict taken, and it stays at 3 on taken and at 0 on not-taken. Every update trains it, whether or not the cache hit.
- R6: Each history register is `HIST_W` bits, selected by the low `HIST_IDX_W` PC bits. An update shifts it left and puts the outcome in bit 0. The cache key of an update uses the history from before the shift.
- R7: An update that misses allocates an entry holding the update's PC and history. It takes a free entry if one exists, and its counter is the second-stage counter moved one step toward the outcome (saturating).
- R8: An update that hits moves that entry's counter one step toward the outcome (saturating) and allocates nothing. On a hit, bit 1 of the entry counter is the prediction.
- R9: When the cache is full, allocation evicts the entry least recently touched, where both allocations and hit updates count as touches and lookups do not.
- R10: Synchronous reset clears all valid bits, histories and cache counters, and sets every second-stage counter to 1 (weakly not taken).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_hit | output | 1 | Prediction came from a valid cache entry |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup and an update can land in the same cycle, including on the very context being trained. The bench provokes this both in a directed case, where a freshly allocated context is looked up while its update is applied, and in random traffic, where roughly a third of the cycles look up the address being resolved. Lookup outputs are sampled before the edge and judged against a reference model that still holds the pre-update state. The model is advanced only after the edge.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT = 2'b01;

    // one saturating step of a two-bit counter toward the outcome
    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
        ctr2_t res;
        if (taken) begin
            res = (cur == 2'b11) ? cur : cur + 2'b01;
        end else begin
            res = (cur == 2'b00) ? cur : cur - 2'b01;
        end
        return res;
    endfunction

endpackage

// File: rtl/cbp_hist_tbl.sv
module cbp_hist_tbl #(
    parameter int HIST_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_taken,
    output logic [HIST_W-1:0] up_hist
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][HIST_W-1:0] hist;
    } hst_t;

    hst_t hst_d, hst_q;

    always_comb begin
        hst_d   = hst_q;
        lk_hist = hst_q.hist[lk_idx];
        up_hist = hst_q.hist[up_idx];
        if (up_valid) begin
            hst_d.hist[up_idx] = {hst_q.hist[up_idx][HIST_W-2:0], up_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_q <= '0;
        end else begin
            hst_q <= hst_d;
        end
    end

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> hst_q.hist[$past(up_idx)][0] == $past(up_taken));

    // R6
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(hst_q));

endmodule

// File: rtl/cbp_base_ctr.sv
module cbp_base_ctr
    import cbp_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_pred,
    input  logic             up_valid,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_taken,
    output ctr2_t            up_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } bst_t;

    bst_t bst_d, bst_q;

    always_comb begin
        bst_d   = bst_q;
        lk_pred = bst_q.ctr[lk_idx][1];
        up_ctr  = bst_q.ctr[up_idx];
        if (up_valid) begin
            bst_d.ctr[up_idx] = ctr_step(bst_q.ctr[up_idx], up_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bst_q.ctr <= {DEPTH{CTR_WEAK_NT}};
        end else begin
            bst_q <= bst_d;
        end
    end

    // R5
    base_sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && up_ctr == 2'b11) |=> bst_q.ctr[$past(up_idx)] == 2'b11);

    // R5
    base_sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_taken && up_ctr == 2'b00) |=> bst_q.ctr[$past(up_idx)] == 2'b00);

endmodule

// File: rtl/cbp_pred_cache.sv
module cbp_pred_cache
    import cbp_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int HIST_W = 4,
    parameter int N_ENT  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [HIST_W-1:0] lk_hist,
    output logic              lk_hit,
    output logic              lk_pred,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [HIST_W-1:0] up_hist,
    input  logic              up_taken,
    input  ctr2_t             up_base_ctr
);
    localparam int AGE_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(N_ENT - 1);

    typedef struct packed {
        logic [N_ENT-1:0]             vld;
        logic [N_ENT-1:0][PC_W-1:0]   pc;
        logic [N_ENT-1:0][HIST_W-1:0] htag;
        logic [N_ENT-1:0][1:0]        ctr;
        logic [N_ENT-1:0][AGE_W-1:0]  age;
    } cst_t;

    cst_t cst_d, cst_q;

    logic [N_ENT-1:0] lk_match, up_match, free_vec, old_vec;
    logic [AGE_W-1:0] hit_idx, free_idx, old_idx, tgt_idx;
    logic             up_hit, has_free;

    // tag compare for both ports and the replacement candidates
    always_comb begin
        lk_pred = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            lk_match[i] = cst_q.vld[i] && (cst_q.pc[i] == lk_pc) && (cst_q.htag[i] == lk_hist);
            up_match[i] = cst_q.vld[i] && (cst_q.pc[i] == up_pc) && (cst_q.htag[i] == up_hist);
            free_vec[i] = !cst_q.vld[i];
            old_vec[i]  = (cst_q.age[i] == AGE_OLDEST);
            lk_pred     = lk_pred | (lk_match[i] & cst_q.ctr[i][1]);
        end
        lk_hit   = |lk_match;
        up_hit   = |up_match;
        has_free = |free_vec;
    end

    // lowest-index encoders
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (up_match[i]) hit_idx  = AGE_W'(i);
            if (free_vec[i]) free_idx = AGE_W'(i);
            if (old_vec[i])  old_idx  = AGE_W'(i);
        end
        if (up_hit) begin
            tgt_idx = hit_idx;
        end else if (has_free) begin
            tgt_idx = free_idx;
        end else begin
            tgt_idx = old_idx;
        end
    end

    // next state: train or allocate, then refresh recency
    always_comb begin
        cst_d = cst_q;
        if (up_valid) begin
            if (up_hit) begin
                cst_d.ctr[tgt_idx] = ctr_step(cst_q.ctr[tgt_idx], up_taken);
            end else begin
                cst_d.vld[tgt_idx]  = 1'b1;
                cst_d.pc[tgt_idx]   = up_pc;
                cst_d.htag[tgt_idx] = up_hist;
                cst_d.ctr[tgt_idx]  = ctr_step(up_base_ctr, up_taken);
            end
            for (int i = 0; i < N_ENT; i++) begin
                if (AGE_W'(i) == tgt_idx) begin
                    cst_d.age[i] = '0;
                end else if (cst_q.age[i] < cst_q.age[tgt_idx]) begin
                    cst_d.age[i] = cst_q.age[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cst_q.vld  <= '0;
            cst_q.pc   <= '0;
            cst_q.htag <= '0;
            cst_q.ctr  <= '0;
            for (int i = 0; i < N_ENT; i++) begin
                cst_q.age[i] <= AGE_W'(i);
            end
        end else begin
            cst_q <= cst_d;
        end
    end

    // R3
    lk_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R3
    up_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(up_match));

    // R9
    lru_single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(old_vec) == 1);

    // R7
    alloc_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_hit && has_free)
        |=> $countones(cst_q.vld) == $past($countones(cst_q.vld)) + 1);

    // R8
    hit_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_hit) |=> $stable(cst_q.vld) && $stable(cst_q.pc));

endmodule

// File: rtl/cached_branch_predictor.sv
module cached_branch_predictor
    import cbp_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int HIST_W     = 4,
    parameter int HIST_IDX_W = 4,
    parameter int BASE_IDX_W = 5,
    parameter int N_ENT      = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    logic [HIST_W-1:0] lk_hist, up_hist;
    logic              base_lk_pred, cache_lk_pred, cache_lk_hit;
    ctr2_t             base_up_ctr;

    cbp_hist_tbl #(
        .HIST_W (HIST_W),
        .IDX_W  (HIST_IDX_W)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (lk_pc[HIST_IDX_W-1:0]),
        .lk_hist  (lk_hist),
        .up_valid (up_valid),
        .up_idx   (up_pc[HIST_IDX_W-1:0]),
        .up_taken (up_taken),
        .up_hist  (up_hist)
    );

    cbp_base_ctr #(
        .IDX_W (BASE_IDX_W)
    ) u_base (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (lk_pc[BASE_IDX_W-1:0]),
        .lk_pred  (base_lk_pred),
        .up_valid (up_valid),
        .up_idx   (up_pc[BASE_IDX_W-1:0]),
        .up_taken (up_taken),
        .up_ctr   (base_up_ctr)
    );

    cbp_pred_cache #(
        .PC_W   (PC_W),
        .HIST_W (HIST_W),
        .N_ENT  (N_ENT)
    ) u_cache (
        .clk         (clk),
        .rst         (rst),
        .lk_pc       (lk_pc),
        .lk_hist     (lk_hist),
        .lk_hit      (cache_lk_hit),
        .lk_pred     (cache_lk_pred),
        .up_valid    (up_valid),
        .up_pc       (up_pc),
        .up_hist     (up_hist),
        .up_taken    (up_taken),
        .up_base_ctr (base_up_ctr)
    );

    always_comb begin
        lk_hit   = cache_lk_hit;
        lk_taken = cache_lk_hit ? cache_lk_pred : base_lk_pred;
    end

    // R2
    no_hit_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

endmodule

// File: tb/cached_branch_predictor_tb.sv
module cached_branch_predictor_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lk_pc = '0;
    logic        lk_hit, lk_taken;
    logic        up_valid = 1'b0;
    logic [15:0] up_pc = '0;
    logic        up_taken = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cached_branch_predictor u_dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    // reference model
    logic [3:0]  m_hist [16];
    logic [1:0]  m_base [32];
    bit          m_vld  [16];
    logic [15:0] m_pc   [16];
    logic [3:0]  m_htag [16];
    logic [1:0]  m_ctr  [16];
    int          m_used [16];
    int          m_time;

    function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
        if (t) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < 16; i++) begin
            m_hist[i] = '0; m_vld[i] = 0; m_ctr[i] = '0; m_used[i] = 0;
            m_pc[i] = '0; m_htag[i] = '0;
        end
        for (int i = 0; i < 32; i++) m_base[i] = 2'd1;
        m_time = 0;
    endfunction

    function automatic int m_find(input logic [15:0] pc, input logic [3:0] h);
        for (int i = 0; i < 16; i++)
            if (m_vld[i] && m_pc[i] == pc && m_htag[i] == h) return i;
        return -1;
    endfunction

    function automatic void m_lookup(input logic [15:0] pc, output logic hit, output logic tk);
        int e;
        e = m_find(pc, m_hist[pc[3:0]]);
        hit = (e >= 0);
        tk  = hit ? m_ctr[e][1] : m_base[pc[4:0]][1];
    endfunction

    function automatic void m_update(input logic [15:0] pc, input logic t);
        int e;
        logic [3:0] h;
        h = m_hist[pc[3:0]];
        e = m_find(pc, h);
        m_time++;
        if (e >= 0) begin
            m_ctr[e] = sat(m_ctr[e], t);
        end else begin
            for (int i = 0; i < 16; i++)
                if (e < 0 && !m_vld[i]) e = i;
            if (e < 0) begin
                e = 0;
                for (int i = 1; i < 16; i++)
                    if (m_used[i] < m_used[e]) e = i;
            end
            m_vld[e] = 1; m_pc[e] = pc; m_htag[e] = h;
            m_ctr[e] = sat(m_base[pc[4:0]], t);
        end
        m_used[e] = m_time;
        m_base[pc[4:0]] = sat(m_base[pc[4:0]], t);
        m_hist[pc[3:0]] = {h[2:0], t};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; up_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_reset();
    endtask

    // one cycle: drive, compare lookup against the pre-update model, then advance
    task automatic step(input logic [15:0] lpc, input logic uv, input logic [15:0] upc, input logic ut);
        logic eh, et;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #1;
        m_lookup(lpc, eh, et);
        check(lk_hit === eh, "R3 hit flag", lk_hit, eh);
        check(lk_taken === et, eh ? "R8 cached direction" : "R4 fallback direction", lk_taken, et);
        @(posedge clk);
        if (uv) m_update(upc, ut);
    endtask

    task automatic probe(input logic [15:0] lpc, input logic eh, input logic et, input string tag);
        @(negedge clk);
        lk_pc = lpc; up_valid = 1'b0;
        #1;
        check(lk_hit === eh, tag, lk_hit, eh);
        check(lk_taken === et, tag, lk_taken, et);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        do_reset();

        // R10 / R2: empty cache, weakly not-taken fallback
        probe(16'h0003, 1'b0, 1'b0, "R10 reset state");
        probe(16'hBEEF, 1'b0, 1'b0, "R2 no hit after reset");

        // R7 allocation then R8 hit training, R6 history moves the key
        step(16'h0021, 1'b1, 16'h0021, 1'b0);
        probe(16'h0021, 1'b1, 1'b0, "R7 allocated entry hits");
        step(16'h0021, 1'b1, 16'h0021, 1'b1);
        probe(16'h0021, 1'b0, 1'b0, "R6 shifted history misses");

        // R1: lookup and update of the same context in one cycle
        do_reset();
        step(16'h0055, 1'b1, 16'h0055, 1'b0);
        @(negedge clk);
        lk_pc = 16'h0055; up_valid = 1'b1; up_pc = 16'h0055; up_taken = 1'b1;
        #1;
        check(lk_hit === 1'b1, "R1 same-cycle hit", lk_hit, 1);
        check(lk_taken === 1'b0, "R1 same-cycle pre-update value", lk_taken, 0);
        @(posedge clk);
        m_update(16'h0055, 1'b1);

        // R5: second-stage counter saturates at 3
        do_reset();
        repeat (3) step(16'h0042, 1'b1, 16'h0042, 1'b1);
        probe(16'h0042, 1'b0, 1'b1, "R5 fallback after taken run");
        step(16'h0042, 1'b1, 16'h0042, 1'b0);
        probe(16'h0042, 1'b0, 1'b1, "R5 saturated counter stays taken");

        // R9 LRU eviction, R3 no aliasing across shared indices
        do_reset();
        for (int i = 0; i < 16; i++) step(16'h0007, 1'b1, 16'h0007 + 16'(i) * 16'h0100, 1'b0);
        step(16'h0007, 1'b1, 16'h0007, 1'b0);
        step(16'h0007, 1'b1, 16'h1007, 1'b0);
        probe(16'h0007, 1'b1, 1'b0, "R9 recently touched entry kept");
        probe(16'h0107, 1'b0, 1'b0, "R9 least recent entry evicted");
        probe(16'h1007, 1'b1, 1'b0, "R9 new entry present");
        probe(16'h1107, 1'b0, 1'b0, "R3 unseen PC on shared index misses");

        // constrained random traffic
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a, b;
            logic        uv, t;
            a  = 16'((($urandom % 3) << 12) | ($urandom % 6));
            b  = ($urandom % 3 == 0) ? a : 16'((($urandom % 3) << 12) | ($urandom % 6));
            uv = ($urandom % 5) != 0;
            t  = (($urandom % 5) == 0) ? ~a[0] : a[0] ^ a[12];
            step(b, uv, a, t);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule